// File: doc/BRIEF.md
# Flash Unlock Command Sequence Decoder

This block sits on the device side of a parallel flash bus with a 19-bit word address and a 16-bit data word. Each host write reaches it as a single-cycle synchronous strobe that carries the latched address and data. The decoder follows the protected multi-cycle unlock sequences. Each sequence opens with two fixed address/data pairs. A command byte follows, and some commands need further cycles after it. When a sequence completes, the decoder issues a one-cycle start pulse for a word program, a sector erase, a block erase or a whole-array erase, together with the target address and data. It also keeps the current read mode: array, identification or query.

Two shortcuts skip the unlock pairs. A lone query-entry write at a fixed short address enters query mode, and a lone exit byte at any address returns the decoder to array reads. Any write that breaks a sequence drops the decoder back to idle with array reads. While the busy input shows an internal operation in progress, every strobe is ignored. The array itself, the operation timing and the filtering of bus glitches belong to other blocks.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After synchronous reset, rd_mode is 0 (array), op_start is 0 and the decoder is idle.
- R2: Only wr_addr[14:0] and wr_data[7:0] take part in command matching. wr_addr[18:15] and wr_data[15:8] have no effect on it.
- R3: The writes 0xAA@0x5555, 0x55@0x2AAA, 0xA0@0x5555 followed by any fourth write produce op_start with op_kind 0 (program), op_addr equal to the full fourth address and op_data equal to the full fourth data.
- R4: The writes 0xAA@0x5555, 0x55@0x2AAA, 0x80@0x5555, 0xAA@0x5555, 0x55@0x2AAA, 0x10@0x5555 produce op_start with op_kind 3 (chip erase), op_addr 0 and op_data 0.
- R5: The same five-write prefix followed by 0x30 at any address produces op_start with op_kind 1 (sector erase) and op_addr equal to that address with bits 10:0 cleared, so bits 18:11 select the sector. op_data is 0.
- R6: The same prefix followed by 0x50 at any address produces op_start with op_kind 2 (block erase) and op_addr equal to that address with bits 14:0 cleared, so bits 18:15 select the block. op_data is 0.
- R7: The two unlock writes followed by 0x90@0x5555 set rd_mode to 1 (identification). Followed by 0x98@0x5555 they set rd_mode to 2 (query).
- R8: From idle, a single write of 0x98@0x0055 sets rd_mode to 2, and a single write of 0xF0 at any address sets rd_mode to 0. The three-write sequence ending in 0xF0@0x5555 also sets rd_mode to 0.
- R9: A write that does not match the expected cycle returns the decoder to idle with rd_mode 0 and no op_start. That aborting write is not taken as the first cycle of a new sequence.
- R10: While busy is 1, strobes are ignored. rd_mode and the sequence position are held, so an exit write has no effect, and an open sequence resumes once busy falls.
- R11: Results appear on the first clock edge after the strobe, and op_start is high for exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_stb | input | 1 | One-cycle host write strobe |
| wr_addr | input | 19 | Latched word address of the write |
| wr_data | input | 16 | Latched data of the write |
| busy | input | 1 | Internal program or erase in progress |
| op_start | output | 1 | One-cycle operation start pulse |
| op_kind | output | 2 | 0 program, 1 sector erase, 2 block erase, 3 chip erase |
| op_addr | output | 19 | Target address, aligned for erases |
| op_data | output | 16 | Word to program, 0 for erases |
| rd_mode | output | 2 | 0 array, 1 identification, 2 query |

## Verification
The sequence state, rd_mode and the operation outputs are all registered from the strobe cycle, so each result is due on the first rising edge after the strobe. op_start must fall again one edge later. The bench drives each strobe for one cycle starting at a falling edge and samples the outputs at the next falling edge, which is half a period after the result edge. It then samples op_start once more a cycle later to confirm the pulse has ended. Where a stimulus is meant to be ignored or to abort a sequence, the bench checks rd_mode and op_start at that same sample point. It then confirms through a later write that the sequence position behaved as the requirement states.

// File: rtl/fcd_pkg.sv
package fcd_pkg;

    localparam int CMP_AW = 15;
    localparam int CMP_DW = 8;

    localparam logic [CMP_AW-1:0] ADR_UNL_A = 15'h5555;
    localparam logic [CMP_AW-1:0] ADR_UNL_B = 15'h2AAA;
    localparam logic [CMP_AW-1:0] ADR_SHORT = 15'h0055;

    localparam logic [CMP_DW-1:0] KEY_A     = 8'hAA;
    localparam logic [CMP_DW-1:0] KEY_B     = 8'h55;
    localparam logic [CMP_DW-1:0] CMD_PROG  = 8'hA0;
    localparam logic [CMP_DW-1:0] CMD_ERPRE = 8'h80;
    localparam logic [CMP_DW-1:0] CMD_IDENT = 8'h90;
    localparam logic [CMP_DW-1:0] CMD_QUERY = 8'h98;
    localparam logic [CMP_DW-1:0] CMD_EXIT  = 8'hF0;
    localparam logic [CMP_DW-1:0] CMD_CHIP  = 8'h10;
    localparam logic [CMP_DW-1:0] CMD_SECT  = 8'h30;
    localparam logic [CMP_DW-1:0] CMD_BLK   = 8'h50;

    typedef enum logic [2:0] {
        S_IDLE, S_UNL1, S_UNL2, S_PROG, S_ER3, S_ER4, S_ER5
    } seq_st_e;

    typedef enum logic [1:0] {
        RM_ARRAY = 2'd0, RM_IDENT = 2'd1, RM_QUERY = 2'd2
    } rd_mode_e;

    typedef enum logic [1:0] {
        OP_PROG = 2'd0, OP_SECT = 2'd1, OP_BLK = 2'd2, OP_CHIP = 2'd3
    } op_kind_e;

    typedef struct packed {
        logic              key_a;    // 0xAA at 0x5555
        logic              key_b;    // 0x55 at 0x2AAA
        logic              at_cmd;   // address 0x5555
        logic              at_short; // address 0x0055
        logic [CMP_DW-1:0] code;
    } cyc_t;

endpackage

// File: rtl/fcd_cycle_match.sv
module fcd_cycle_match
    import fcd_pkg::*;
(
    input  logic [CMP_AW-1:0] addr,
    input  logic [CMP_DW-1:0] data,
    output cyc_t              cyc
);
    always_comb begin
        cyc.at_cmd   = (addr == ADR_UNL_A);
        cyc.at_short = (addr == ADR_SHORT);
        cyc.code     = data;
        cyc.key_a    = cyc.at_cmd && (data == KEY_A);
        cyc.key_b    = (addr == ADR_UNL_B) && (data == KEY_B);
    end
endmodule

// File: rtl/fcd_seq_fsm.sv
module fcd_seq_fsm
    import fcd_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     stb,
    input  logic     busy,
    input  cyc_t     cyc,
    output rd_mode_e mode,
    output logic     go,
    output op_kind_e go_kind
);
    seq_st_e  st_q, st_n;
    rd_mode_e mode_q, mode_n;

    always_comb begin
        st_n    = st_q;
        mode_n  = mode_q;
        go      = 1'b0;
        go_kind = OP_PROG;
        if (stb && !busy) begin
            st_n = S_IDLE;
            unique case (st_q)
                S_IDLE: begin
                    if (cyc.key_a)
                        st_n = S_UNL1;
                    else if (cyc.at_short && cyc.code == CMD_QUERY)
                        mode_n = RM_QUERY;
                    else
                        mode_n = RM_ARRAY; // exit byte or stray write
                end
                S_UNL1: if (cyc.key_b) st_n = S_UNL2; else mode_n = RM_ARRAY;
                S_UNL2: begin
                    mode_n = RM_ARRAY;
                    if (cyc.at_cmd) begin
                        case (cyc.code)
                            CMD_PROG:  begin st_n = S_PROG; mode_n = mode_q; end
                            CMD_ERPRE: begin st_n = S_ER3;  mode_n = mode_q; end
                            CMD_IDENT: mode_n = RM_IDENT;
                            CMD_QUERY: mode_n = RM_QUERY;
                            default:   mode_n = RM_ARRAY;
                        endcase
                    end
                end
                S_PROG: begin
                    go      = 1'b1;
                    go_kind = OP_PROG;
                end
                S_ER3: if (cyc.key_a) st_n = S_ER4; else mode_n = RM_ARRAY;
                S_ER4: if (cyc.key_b) st_n = S_ER5; else mode_n = RM_ARRAY;
                S_ER5: begin
                    if (cyc.at_cmd && cyc.code == CMD_CHIP) begin
                        go = 1'b1; go_kind = OP_CHIP;
                    end else if (cyc.code == CMD_SECT) begin
                        go = 1'b1; go_kind = OP_SECT;
                    end else if (cyc.code == CMD_BLK) begin
                        go = 1'b1; go_kind = OP_BLK;
                    end else begin
                        mode_n = RM_ARRAY;
                    end
                end
                default: mode_n = RM_ARRAY;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= S_IDLE;
            mode_q <= RM_ARRAY;
        end else begin
            st_q   <= st_n;
            mode_q <= mode_n;
        end
    end

    assign mode = mode_q;

    // R10
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!stb || busy) |=> ($stable(mode_q) && $stable(st_q)));

endmodule

// File: rtl/fcd_op_reg.sv
module fcd_op_reg
    import fcd_pkg::*;
#(
    parameter int ADDR_W   = 19,
    parameter int DATA_W   = 16,
    parameter int SECT_LSB = 11,
    parameter int BLK_LSB  = 15
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              go,
    input  op_kind_e          go_kind,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] data,
    output logic              op_start,
    output op_kind_e          op_kind,
    output logic [ADDR_W-1:0] op_addr,
    output logic [DATA_W-1:0] op_data
);
    logic [ADDR_W-1:0] sect_addr, blk_addr, tgt_addr;

    assign sect_addr = {addr[ADDR_W-1:SECT_LSB], {SECT_LSB{1'b0}}};
    assign blk_addr  = {addr[ADDR_W-1:BLK_LSB],  {BLK_LSB{1'b0}}};

    always_comb begin
        unique case (go_kind)
            OP_PROG: tgt_addr = addr;
            OP_SECT: tgt_addr = sect_addr;
            OP_BLK:  tgt_addr = blk_addr;
            default: tgt_addr = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            op_start <= 1'b0;
            op_kind  <= OP_PROG;
            op_addr  <= '0;
            op_data  <= '0;
        end else begin
            op_start <= go;
            if (go) begin
                op_kind <= go_kind;
                op_addr <= tgt_addr;
                op_data <= (go_kind == OP_PROG) ? data : '0;
            end
        end
    end

    // R11
    pulse_one_chk: assert property (@(posedge clk) disable iff (rst)
        op_start |=> !op_start);
    // R4
    chip_addr_chk: assert property (@(posedge clk) disable iff (rst)
        (op_start && op_kind == OP_CHIP) |-> (op_addr == '0 && op_data == '0));
    // R5
    sect_align_chk: assert property (@(posedge clk) disable iff (rst)
        (op_start && op_kind == OP_SECT) |-> (op_addr[SECT_LSB-1:0] == '0));
    // R6
    blk_align_chk: assert property (@(posedge clk) disable iff (rst)
        (op_start && op_kind == OP_BLK) |-> (op_addr[BLK_LSB-1:0] == '0));

endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
    import fcd_pkg::*;
#(
    parameter int ADDR_W   = 19,
    parameter int DATA_W   = 16,
    parameter int SECT_LSB = 11,
    parameter int BLK_LSB  = 15
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_stb,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              busy,
    output logic              op_start,
    output logic [1:0]        op_kind,
    output logic [ADDR_W-1:0] op_addr,
    output logic [DATA_W-1:0] op_data,
    output logic [1:0]        rd_mode
);
    cyc_t     cyc;
    rd_mode_e mode;
    logic     go;
    op_kind_e go_kind, kind_q;

    fcd_cycle_match u_match (
        .addr (wr_addr[CMP_AW-1:0]),
        .data (wr_data[CMP_DW-1:0]),
        .cyc  (cyc)
    );

    fcd_seq_fsm u_fsm (
        .clk     (clk),
        .rst     (rst),
        .stb     (wr_stb),
        .busy    (busy),
        .cyc     (cyc),
        .mode    (mode),
        .go      (go),
        .go_kind (go_kind)
    );

    fcd_op_reg #(
        .ADDR_W   (ADDR_W),
        .DATA_W   (DATA_W),
        .SECT_LSB (SECT_LSB),
        .BLK_LSB  (BLK_LSB)
    ) u_op (
        .clk      (clk),
        .rst      (rst),
        .go       (go),
        .go_kind  (go_kind),
        .addr     (wr_addr),
        .data     (wr_data),
        .op_start (op_start),
        .op_kind  (kind_q),
        .op_addr  (op_addr),
        .op_data  (op_data)
    );

    assign op_kind = kind_q;
    assign rd_mode = mode;

endmodule

// File: tb/sim_flash_cmd_decoder.sv
module sim_flash_cmd_decoder;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_stb = 1'b0;
    logic [18:0] wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic        busy = 1'b0;
    logic        op_start;
    logic [1:0]  op_kind;
    logic [18:0] op_addr;
    logic [15:0] op_data;
    logic [1:0]  rd_mode;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    logic        c_start;
    logic [1:0]  c_kind;
    logic [18:0] c_addr;
    logic [15:0] c_data;
    logic [1:0]  c_mode;

    always #10 clk = ~clk;

    flash_cmd_decoder u0 (
        .clk(clk), .rst(rst), .wr_stb(wr_stb), .wr_addr(wr_addr),
        .wr_data(wr_data), .busy(busy), .op_start(op_start),
        .op_kind(op_kind), .op_addr(op_addr), .op_data(op_data),
        .rd_mode(rd_mode)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // One strobe; outputs captured half a cycle after the edge that takes it.
    task automatic wr(input logic [18:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_stb = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_stb = 1'b0;
        c_start = op_start; c_kind = op_kind; c_addr = op_addr;
        c_data = op_data; c_mode = rd_mode;
    endtask

    task automatic unlock();
        wr(19'h05555, 16'h00AA);
        wr(19'h02AAA, 16'h0055);
    endtask

    task automatic erase_prefix();
        unlock();
        wr(19'h05555, 16'h0080);
        unlock();
    endtask

    task automatic t_reset();
        chk("R1 rd_mode", rd_mode, 0);
        chk("R1 op_start", op_start, 0);
        // idle: a stray second-cycle write does nothing
        wr(19'h02AAA, 16'h0055);
        chk("R1 idle stray start", c_start, 0);
    endtask

    task automatic t_program();
        // R2: upper address bits and upper data byte are don't-care
        wr(19'h4D555, 16'hC3AA);
        wr(19'h3AAAA, 16'h1255);
        wr(19'h75555, 16'hFFA0);
        chk("R2 no early start", c_start, 0);
        wr(19'h12345, 16'hBEEF);
        chk("R3 start", c_start, 1);
        chk("R3 kind", c_kind, 0);
        chk("R3 addr", c_addr, 19'h12345);
        chk("R3 data", c_data, 16'hBEEF);
        @(negedge clk);
        chk("R11 pulse ends", op_start, 0);
        wr(19'h12346, 16'h0001);
        chk("R3 back to idle", c_start, 0);
    endtask

    task automatic t_chip();
        erase_prefix();
        wr(19'h05555, 16'h0010);
        chk("R4 start", c_start, 1);
        chk("R4 kind", c_kind, 3);
        chk("R4 addr", c_addr, 0);
        chk("R4 data", c_data, 0);
        @(negedge clk);
        chk("R11 chip pulse ends", op_start, 0);
    endtask

    task automatic t_sector();
        logic [18:0] a;
        a = 19'h5ABCD;
        erase_prefix();
        wr(a, 16'hAB30);
        chk("R5 start", c_start, 1);
        chk("R5 kind", c_kind, 1);
        chk("R5 addr", c_addr, a & ~19'h007FF);
        chk("R5 data", c_data, 0);
    endtask

    task automatic t_block();
        logic [18:0] a;
        a = 19'h5ABCD;
        erase_prefix();
        wr(a, 16'h0050);
        chk("R6 start", c_start, 1);
        chk("R6 kind", c_kind, 2);
        chk("R6 addr", c_addr, a & ~19'h07FFF);
    endtask

    task automatic t_modes();
        unlock(); wr(19'h05555, 16'h0090);
        chk("R7 ident", c_mode, 1);
        wr(19'h00123, 16'h00F0);
        chk("R8 short exit", c_mode, 0);
        unlock(); wr(19'h05555, 16'h0098);
        chk("R7 query", c_mode, 2);
        unlock();
        chk("R7 mode held mid-seq", c_mode, 2);
        wr(19'h05555, 16'h00F0);
        chk("R8 long exit", c_mode, 0);
        wr(19'h00055, 16'h0098);
        chk("R8 short query", c_mode, 2);
        wr(19'h7FFFF, 16'h00F0);
        chk("R8 exit any addr", c_mode, 0);
        wr(19'h00056, 16'h0098);
        chk("R8 short query wrong addr", c_mode, 0);
    endtask

    task automatic t_abort();
        unlock(); wr(19'h05555, 16'h0090);
        wr(19'h05555, 16'h00AA);
        wr(19'h02AAB, 16'h0055);
        chk("R9 abort to array", c_mode, 0);
        // aborting AA is not a fresh first cycle
        unlock(); wr(19'h05555, 16'h0090);
        wr(19'h05555, 16'h00AA);
        wr(19'h05555, 16'h00AA);
        chk("R9 abort mode", c_mode, 0);
        wr(19'h02AAA, 16'h0055);
        wr(19'h05555, 16'h00A0);
        wr(19'h00100, 16'h1234);
        chk("R9 no restart", c_start, 0);
        erase_prefix();
        wr(19'h05555, 16'h0020);
        chk("R9 bad erase code", c_start, 0);
        unlock(); wr(19'h05555, 16'h00A1);
        wr(19'h00200, 16'h5555);
        chk("R9 bad third byte", c_start, 0);
    endtask

    task automatic t_busy();
        unlock(); wr(19'h05555, 16'h0090);
        busy = 1'b1;
        wr(19'h00000, 16'h00F0);
        chk("R10 exit ignored", c_mode, 1);
        busy = 1'b0;
        unlock(); wr(19'h05555, 16'h00A0);
        busy = 1'b1;
        wr(19'h00ABC, 16'h1111);
        chk("R10 no start while busy", c_start, 0);
        busy = 1'b0;
        wr(19'h00ABD, 16'h2222);
        chk("R10 resumed start", c_start, 1);
        chk("R10 resumed addr", c_addr, 19'h00ABD);
        chk("R10 resumed data", c_data, 16'h2222);
        wr(19'h00000, 16'h00F0);
        chk("R10 exit after busy", c_mode, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_program();
        t_chip();
        t_sector();
        t_block();
        t_modes();
        t_abort();
        t_busy();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule